// File: doc/BRIEF.md
# Wrapping Six-Entry Return Stack

This block is a small last-in-first-out store for return addresses in a 16-bit signal processor. The processor sees it as a single register: a write to that register is a push and a read from it is a pop. Six 16-bit slots are indexed by a 3-bit pointer. The pointer gives the number of slots in use and also the next free slot.

The block never stalls and never traps. A push made when the pointer already reads six or more sends the pointer back to slot 0 before the store and raises an overflow pulse. A pop made when the pointer is zero moves the pointer to the top slot, returns that slot, and raises an underflow pulse. The popped value is registered and holds until the next pop. The pointer is always visible at the ports. Instruction decode and the program counter belong to the surrounding core.

Top module: `ret_stack_top`

## Requirements
- R1: After reset the pointer is 0, both event flags are 0 and the popped-data output is 0.
- R2: A push with the pointer below 6 stores the write data in the slot named by the pointer. The pointer then shows one more on the cycle after the clock edge.
- R3: A pop with a nonzero pointer first lowers the pointer by one. It then presents the slot named by the new pointer on the popped-data output on the cycle after the edge, so values come back in reverse order of pushing.
- R4: A push with the pointer at 6 or 7 stores the data in slot 0 and leaves the pointer at 1. It drives the overflow flag high for that one cycle.
- R5: A pop with the pointer at 0 leaves the pointer at 5 and returns slot 5. It drives the underflow flag high for that one cycle.
- R6: Each event flag is high for exactly one cycle per wrapping operation, the two flags are never high together, and neither rises without the matching operation.
- R7: When push and pop are both high in the same cycle, nothing happens. The pointer, the popped data, the flags and the slot contents all stay as they were.
- R8: The popped-data output keeps its value through cycles that carry no pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push strobe (register write) |
| pop_i | input | 1 | Pop strobe (register read) |
| wr_data_i | input | 16 | Value to push |
| rd_data_o | output | 16 | Most recently popped value |
| ptr_o | output | 3 | Current stack pointer |
| ovf_o | output | 1 | One-cycle overflow event |
| unf_o | output | 1 | One-cycle underflow event |

## Verification
The assertions assume the pointer can only reach 7 through a fault. After reset it moves one step at a time, so it stays between 0 and 6, and the bench drives it only through pushes and pops. The assertions also assume each strobe is a plain level sampled at the edge. The bench changes every input on the falling edge and holds it for one full cycle, and it raises both strobes together only in the scenario that checks that the combination is ignored.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } rs_op_e;

    // A cycle with both strobes high counts as idle.
    function automatic rs_op_e rs_decode(input logic push, input logic pop);
        if (push && !pop) return OP_PUSH;
        if (pop && !push) return OP_POP;
        return OP_IDLE;
    endfunction

endpackage

// File: rtl/rs_ptr_ctrl.sv
module rs_ptr_ctrl #(
    parameter int DEPTH = 6,
    parameter int PTR_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic             pop_i,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_idx_o,
    output logic             rd_en_o,
    output logic [PTR_W-1:0] rd_idx_o,
    output logic [PTR_W-1:0] ptr_o,
    output logic             ovf_o,
    output logic             unf_o
);
    import rs_pkg::*;

    localparam logic [PTR_W-1:0] LIMIT = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] TOP   = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] ONE   = PTR_W'(1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             ovf;
        logic             unf;
    } ctrl_t;

    ctrl_t  st_d, st_q;
    rs_op_e op;

    always_comb begin
        op       = rs_decode(push_i, pop_i);
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        wr_en_o  = 1'b0;
        wr_idx_o = st_q.ptr;
        rd_en_o  = 1'b0;
        rd_idx_o = st_q.ptr - ONE;
        unique case (op)
            OP_PUSH: begin
                wr_en_o = 1'b1;
                if (st_q.ptr >= LIMIT) begin
                    wr_idx_o = '0;
                    st_d.ptr = ONE;
                    st_d.ovf = 1'b1;
                end else begin
                    st_d.ptr = st_q.ptr + ONE;
                end
            end
            OP_POP: begin
                rd_en_o = 1'b1;
                if (st_q.ptr == '0) begin
                    rd_idx_o = TOP;
                    st_d.ptr = TOP;
                    st_d.unf = 1'b1;
                end else begin
                    st_d.ptr = st_q.ptr - ONE;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ptr_o = st_q.ptr;
    assign ovf_o = st_q.ovf;
    assign unf_o = st_q.unf;

    a_r2_push_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !pop_i && st_q.ptr < LIMIT) |=> (st_q.ptr == PTR_W'($past(st_q.ptr) + 1)));
    a_r3_pop_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_i && !push_i && st_q.ptr != '0) |=> (st_q.ptr == PTR_W'($past(st_q.ptr) - 1)));
    a_r4_ovf_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !pop_i && st_q.ptr >= LIMIT) |=> (st_q.ptr == ONE && ovf_o));
    a_r5_unf_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_i && !push_i && st_q.ptr == '0) |=> (st_q.ptr == TOP && unf_o));
    a_r6_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({ovf_o, unf_o}));
    a_r6_ovf_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |=> !ovf_o);
    a_r6_unf_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unf_o |=> !unf_o);
    a_r7_both_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && pop_i) |=> ($stable(st_q.ptr) && !ovf_o && !unf_o));
    a_r2_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.ptr <= LIMIT);

endmodule

// File: rtl/rs_store.sv
module rs_store #(
    parameter int DEPTH = 6,
    parameter int WIDTH = 16,
    parameter int PTR_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [PTR_W-1:0] wr_idx_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             rd_en_i,
    input  logic [PTR_W-1:0] rd_idx_i,
    output logic [WIDTH-1:0] rd_data_o
);
    logic [WIDTH-1:0] slot_d [DEPTH];
    logic [WIDTH-1:0] slot_q [DEPTH];
    logic [WIDTH-1:0] rd_d, rd_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_comb begin
            slot_d[i] = slot_q[i];
            if (wr_en_i && wr_idx_i == PTR_W'(i)) slot_d[i] = wr_data_i;
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) slot_q[i] <= '0;
            else         slot_q[i] <= slot_d[i];
        end
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en_i) begin
            rd_d = '0;
            for (int k = 0; k < DEPTH; k++) begin
                if (rd_idx_i == PTR_W'(k)) rd_d = slot_q[k];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rd_q <= '0;
        else         rd_q <= rd_d;
    end

    assign rd_data_o = rd_q;

    a_r8_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rd_q));
    a_r7_no_dual_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && rd_en_i));

endmodule

// File: rtl/ret_stack_top.sv
module ret_stack_top #(
    parameter int DEPTH = 6,
    parameter int WIDTH = 16,
    parameter int PTR_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] wr_data_i,
    output logic [WIDTH-1:0] rd_data_o,
    output logic [PTR_W-1:0] ptr_o,
    output logic             ovf_o,
    output logic             unf_o
);
    localparam int PTR_MIN = $clog2(DEPTH + 1);

    logic             wr_en, rd_en;
    logic [PTR_W-1:0] wr_idx, rd_idx;

    initial begin
        a_r1_ptr_width: assert (PTR_W >= PTR_MIN);
    end

    rs_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) ctrl_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .push_i   (push_i),
        .pop_i    (pop_i),
        .wr_en_o  (wr_en),
        .wr_idx_o (wr_idx),
        .rd_en_o  (rd_en),
        .rd_idx_o (rd_idx),
        .ptr_o    (ptr_o),
        .ovf_o    (ovf_o),
        .unf_o    (unf_o)
    );

    rs_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PTR_W(PTR_W)) store_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data_i),
        .rd_en_i   (rd_en),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: tb/ret_stack_top_tb_top.sv
`timescale 1ns/1ps
module ret_stack_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push = 1'b0;
    logic        pop = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [2:0]  ptr;
    logic        ovf, unf;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ret_stack_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .push_i(push), .pop_i(pop),
        .wr_data_i(wdata), .rd_data_o(rdata), .ptr_o(ptr),
        .ovf_o(ovf), .unf_o(unf)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle of strobes starting at a falling edge, return at the next falling edge.
    task automatic cycle(input bit p, input bit q, input logic [15:0] d);
        push = p; pop = q; wdata = d;
        @(negedge clk);
        push = 1'b0; pop = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 ptr", ptr, 0);
        check("R1 ovf", ovf, 0);
        check("R1 unf", unf, 0);
        check("R1 rdata", rdata, 0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 6; i++) begin
            cycle(1, 0, 16'hA000 + 16'(i));
            check("R2 ptr after push", ptr, i + 1);
            check("R2 no ovf", ovf, 0);
        end
    endtask

    task automatic t_pop_full();
        cycle(0, 1, 16'h0);
        check("R3 ptr after pop", ptr, 5);
        check("R3 data", rdata, 16'hA005);
        check("R6 no unf", unf, 0);
        cycle(1, 0, 16'hA005);
        check("R2 refill ptr", ptr, 6);
    endtask

    task automatic t_overflow();
        cycle(1, 0, 16'hBEEF);
        check("R4 ptr", ptr, 1);
        check("R4 ovf", ovf, 1);
        check("R6 unf quiet", unf, 0);
        cycle(0, 0, 16'h0);
        check("R6 ovf pulse ends", ovf, 0);
        cycle(0, 1, 16'h0);
        check("R4 slot0 holds new value", rdata, 16'hBEEF);
        check("R3 ptr", ptr, 0);
    endtask

    task automatic t_underflow();
        cycle(0, 1, 16'h0);
        check("R5 ptr", ptr, 5);
        check("R5 data", rdata, 16'hA005);
        check("R5 unf", unf, 1);
        check("R6 ovf quiet", ovf, 0);
        cycle(0, 0, 16'h0);
        check("R6 unf pulse ends", unf, 0);
    endtask

    task automatic t_both();
        cycle(1, 1, 16'h5555);
        check("R7 ptr", ptr, 5);
        check("R7 data", rdata, 16'hA005);
        check("R7 ovf", ovf, 0);
        check("R7 unf", unf, 0);
        cycle(0, 1, 16'h0);
        check("R7 contents intact", rdata, 16'hA004);
        check("R3 ptr", ptr, 4);
    endtask

    task automatic t_hold();
        for (int i = 0; i < 3; i++) begin
            cycle(0, 0, 16'hFFFF);
            check("R8 hold", rdata, 16'hA004);
        end
        cycle(1, 0, 16'h1234);
        check("R8 hold across push", rdata, 16'hA004);
        cycle(0, 1, 16'h0);
        check("R3 LIFO", rdata, 16'h1234);
        cycle(0, 1, 16'h0);
        check("R3 LIFO deeper", rdata, 16'hA003);
        check("R3 ptr", ptr, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_pop_full();
        t_overflow();
        t_underflow();
        t_both();
        t_hold();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule